// File: doc/BRIEF.md
# Banked GPIO controller with edge interrupts

This block is a register-mapped general purpose I/O peripheral. Its pins are grouped into register sets of 32 pins each. Every set has its own direction mask, an output latch that changes through write-one set and write-one clear words, a synchronized view of the pin levels, separate rising and falling edge enable masks, and an interrupt status word. Bits in the status word are latched by enabled edges and cleared by writing ones.

Each 16-pin half of a set drives one bank interrupt line. The line is high while any status bit in its half is set and the line's bit in a shared bank enable word is 1. A host reaches all of this through a plain 32-bit read/write port. Reads are combinational within the same cycle, and writes take effect at the clock edge.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every direction bit reads 1, and output data, both edge masks, all status words and the bank enable word read 0. pin_oe and bank_irq are all 0.
- R2: A direction bit of 1 makes the pin an input (pin_oe low). A direction bit of 0 makes it drive its output latch bit on pin_out (pin_oe high). Set k's direction word is at 0x10 + 0x28*k.
- R3: Writing to the set-data word (offset +0x08 in a set) sets the output bits written as 1. Writing to the clear-data word (+0x0C) clears the bits written as 1. Bits written as 0 keep their value. The output data word (+0x04) can also be written directly. Reads of +0x04, +0x08 and +0x0C all return the output latch.
- R4: The input data word (+0x10) returns the pin level through a two-flop synchronizer. A pin change made just before clock edge n can be read after edge n+1 and not after edge n. This holds for output pins too.
- R5: Writing ones to +0x14 enables rising edge detection for those pins, and writing ones to +0x18 disables it. Reads of either word return the rising mask. An enabled rising edge sets the pin's bit in the status word (+0x24).
- R6: Writing ones to +0x1C enables falling edge detection, and writing ones to +0x20 disables it. Reads of either word return the falling mask. A pin with both edges enabled latches status on either edge.
- R7: Writing ones to the status word clears those bits. An edge detected in the same cycle as the clear on that bit keeps the bit set.
- R8: Bank line 2k covers status bits 15:0 of set k, and bank line 2k+1 covers bits 31:16. Each line is ANDed with bit 2k or 2k+1 of the bank enable word at 0x08.
- R9: Reads of unmapped addresses return 0. A write to the input data word changes no state.
- R10: When the bus read strobe is low, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pin_in | input | 32*NUM_SETS (64) | Pin levels from the pads |
| pin_out | output | 32*NUM_SETS (64) | Output latch values to the pads |
| pin_oe | output | 32*NUM_SETS (64) | Pad drive enables, high for output pins |
| bank_irq | output | 2*NUM_SETS (4) | Bank interrupt lines |

## Verification
The bench uses the default NUM_SETS of 2, which gives 64 pins and four bank lines. With two sets, the 0x28 stride to the second set is exercised. The address just past the last set can be checked as unmapped. Interrupt routing is tested into both halves of the upper set. The same-cycle clear and edge collision is timed against the two synchronizer stages.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Word index inside one 32-pin register set; order is the address order
    typedef enum logic [3:0] {
        W_DIR  = 4'd0,
        W_OUT  = 4'd1,
        W_SET  = 4'd2,
        W_CLR  = 4'd3,
        W_IN   = 4'd4,
        W_SETR = 4'd5,
        W_CLRR = 4'd6,
        W_SETF = 4'd7,
        W_CLRF = 4'd8,
        W_STAT = 4'd9
    } gpio_word_e;

    localparam int SET_PINS    = 32;
    localparam int SET_WORDS   = 10;
    localparam int SET_BASE    = 'h10;
    localparam int SET_STRIDE  = 'h28;
    localparam int BANK_EN_OFS = 'h08;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_out  <= '0;
        end else begin
            stage1 <= d_in;
            d_out  <= stage1;
        end
    end
endmodule

// File: rtl/gpio_regset.sv
module gpio_regset
    import gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  gpio_word_e          word,
    input  logic [31:0]         wdata,
    input  logic [SET_PINS-1:0] pins,
    output logic [31:0]         rdata,
    output logic [SET_PINS-1:0] out_q,
    output logic [SET_PINS-1:0] oe,
    output logic [SET_PINS-1:0] status_q
);
    logic [SET_PINS-1:0] dir_q, rise_q, fall_q;
    logic [SET_PINS-1:0] level, level_d, edge_hit, clr_mask;

    gpio_sync #(.WIDTH(SET_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pins),
        .d_out (level)
    );

    always_comb begin
        edge_hit = (rise_q & level & ~level_d) | (fall_q & ~level & level_d);
        clr_mask = (wr_en && word == W_STAT) ? wdata : '0;
        oe       = ~dir_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= '1;
            out_q    <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            status_q <= '0;
            level_d  <= '0;
        end else begin
            level_d  <= level;
            // a fresh edge outranks a same-cycle clear
            status_q <= (status_q & ~clr_mask) | edge_hit;
            if (wr_en) begin
                unique case (word)
                    W_DIR:  dir_q  <= wdata;
                    W_OUT:  out_q  <= wdata;
                    W_SET:  out_q  <= out_q | wdata;
                    W_CLR:  out_q  <= out_q & ~wdata;
                    W_SETR: rise_q <= rise_q | wdata;
                    W_CLRR: rise_q <= rise_q & ~wdata;
                    W_SETF: fall_q <= fall_q | wdata;
                    W_CLRF: fall_q <= fall_q & ~wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (word)
            W_DIR:                rdata = dir_q;
            W_OUT, W_SET, W_CLR:  rdata = out_q;
            W_IN:                 rdata = level;
            W_SETR, W_CLRR:       rdata = rise_q;
            W_SETF, W_CLRF:       rdata = fall_q;
            W_STAT:               rdata = status_q;
            default:              rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic [NUM_SETS*SET_PINS-1:0] pin_in,
    output logic [NUM_SETS*SET_PINS-1:0] pin_out,
    output logic [NUM_SETS*SET_PINS-1:0] pin_oe,
    output logic [2*NUM_SETS-1:0]        bank_irq
);
    localparam int NUM_BANKS = 2 * NUM_SETS;
    localparam int HALF      = SET_PINS / 2;

    logic [NUM_BANKS-1:0] bank_en_q;
    logic [NUM_SETS-1:0]  set_hit;
    logic [31:0]          set_rdata [NUM_SETS];
    logic                 en_hit;

    assign en_hit = (bus_addr == ADDR_W'(BANK_EN_OFS));

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        localparam logic [ADDR_W-1:0] BASE_K = ADDR_W'(SET_BASE + k * SET_STRIDE);
        logic [ADDR_W-1:0]   ofs;
        logic [SET_PINS-1:0] status;

        assign ofs        = bus_addr - BASE_K;
        assign set_hit[k] = (bus_addr >= BASE_K) && (ofs < ADDR_W'(4 * SET_WORDS))
                            && (bus_addr[1:0] == 2'b00);

        gpio_regset u_set (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr && set_hit[k]),
            .word     (gpio_word_e'(ofs[5:2])),
            .wdata    (bus_wdata),
            .pins     (pin_in[k*SET_PINS +: SET_PINS]),
            .rdata    (set_rdata[k]),
            .out_q    (pin_out[k*SET_PINS +: SET_PINS]),
            .oe       (pin_oe[k*SET_PINS +: SET_PINS]),
            .status_q (status)
        );

        assign bank_irq[2*k]   = (|status[HALF-1:0])        & bank_en_q[2*k];
        assign bank_irq[2*k+1] = (|status[SET_PINS-1:HALF]) & bank_en_q[2*k+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bank_en_q <= '0;
        else if (bus_wr && en_hit)
            bank_en_q <= bus_wdata[NUM_BANKS-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (en_hit)
                bus_rdata = 32'(bank_en_q);
            for (int k = 0; k < NUM_SETS; k++)
                if (set_hit[k])
                    bus_rdata = set_rdata[k];
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [31:0]             bus_rdata,
    input logic [NUM_SETS*32-1:0]  pin_out,
    input logic [NUM_SETS*32-1:0]  pin_oe,
    input logic [2*NUM_SETS-1:0]   bank_irq
);
    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'('h18);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'('h1C);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] A_HOLE = ADDR_W'('h10 + NUM_SETS * 'h28);

    // R3: a set-data write drives the written bits high
    a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SET0) |=>
            ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: a clear-data write drives the written bits low
    a_r3_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLR0) |=> ((pin_out[31:0] & $past(bus_wdata)) == 32'd0));

    // R2: pad outputs only move after a bus write
    a_r2_pads_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

    // R8: clearing the bank enable word silences every line
    a_r8_enable_clear_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN && bus_wdata[2*NUM_SETS-1:0] == '0) |=> (bank_irq == '0));

    // R9: the first address past the last set reads as zero
    a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_HOLE) |-> (bus_rdata == 32'd0));

    // R10: no read strobe, no read data
    a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 32'd0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .bank_irq  (bank_irq)
);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out, pin_oe;
    logic [3:0]  bank_irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1;
        chk(req, 64'(bus_rdata), 64'(exp));
        bus_rd = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 pin_oe", pin_oe, 64'd0);
        chk("R1 bank_irq", 64'(bank_irq), 64'd0);
        rd_chk("R1 dir0", 8'h10, 32'hFFFF_FFFF);
        rd_chk("R1 dir1", 8'h38, 32'hFFFF_FFFF);
        rd_chk("R1 out0", 8'h14, 32'd0);
        rd_chk("R1 rise1", 8'h4C, 32'd0);
        rd_chk("R1 fall0", 8'h2C, 32'd0);
        rd_chk("R1 stat1", 8'h5C, 32'd0);
        rd_chk("R1 bank_en", 8'h08, 32'd0);
    endtask

    task automatic t_direction();
        wr(8'h10, 32'hFFFF_0000);
        wr(8'h38, 32'h0FFF_FFFF);
        @(negedge clk);
        chk("R2 oe", pin_oe, {32'hF000_0000, 32'h0000_FFFF});
    endtask

    task automatic t_set_clear();
        wr(8'h18, 32'h0000_00F0);
        wr(8'h18, 32'h0000_0003);
        @(negedge clk);
        chk("R3 set accumulates", pin_out[31:0], 64'h0000_00F3);
        wr(8'h1C, 32'h0000_0030);
        rd_chk("R3 clear readback", 8'h1C, 32'h0000_00C3);
        rd_chk("R3 set readback", 8'h18, 32'h0000_00C3);
        wr(8'h3C, 32'hDEAD_BEEF);
        wr(8'h44, 32'h0000_00FF);
        @(negedge clk);
        chk("R3 set1 direct+clear", pin_out[63:32], 64'hDEAD_BE00);
    endtask

    task automatic t_input_sync();
        @(negedge clk);
        pin_in = {32'h5A00_0000, 32'h0000_00A5};
        @(negedge clk);
        bus_rd = 1; bus_addr = 8'h20; #1;
        chk("R4 one stage stale", 64'(bus_rdata), 64'd0);
        bus_rd = 0;
        @(negedge clk);
        bus_rd = 1; bus_addr = 8'h20; #1;
        chk("R4 two stages new", 64'(bus_rdata), 64'h0000_00A5);
        bus_rd = 0;
        rd_chk("R4 output pin reads level", 8'h48, 32'h5A00_0000);
        wr(8'h20, 32'hFFFF_FFFF);
        rd_chk("R9 write to input word ignored", 8'h10, 32'hFFFF_0000);
        @(negedge clk);
        pin_in = '0;
        settle();
    endtask

    task automatic t_rising();
        wr(8'h24, 32'h0000_0006);
        wr(8'h28, 32'h0000_0004);
        rd_chk("R5 rise mask", 8'h28, 32'h0000_0002);
        @(negedge clk); pin_in[2:1] = 2'b11; settle();
        rd_chk("R5 rising latch", 8'h34, 32'h0000_0002);
        @(negedge clk); pin_in[2:1] = 2'b00; settle();
        rd_chk("R5 falling ignored", 8'h34, 32'h0000_0002);
        wr(8'h34, 32'hFFFF_FFFF);
        rd_chk("R7 w1c", 8'h34, 32'd0);
    endtask

    task automatic t_falling_both();
        wr(8'h54, 32'h0001_0001);
        wr(8'h4C, 32'h0000_0001);
        rd_chk("R6 fall mask", 8'h58, 32'h0001_0001);
        @(negedge clk); pin_in[32] = 1; pin_in[48] = 1; settle();
        rd_chk("R6 both: rise latches", 8'h5C, 32'h0000_0001);
        wr(8'h5C, 32'h0000_0001);
        @(negedge clk); pin_in[32] = 0; pin_in[48] = 0; settle();
        rd_chk("R6 falls latch", 8'h5C, 32'h0001_0001);
        wr(8'h58, 32'h0001_0001);
        wr(8'h50, 32'h0000_0001);
        wr(8'h5C, 32'h0001_0001);
        rd_chk("R6 disabled", 8'h54, 32'd0);
    endtask

    task automatic t_collision();
        wr(8'h24, 32'h0000_0020);
        wr(8'h2C, 32'h0000_0020);
        @(negedge clk); pin_in[5] = 1; settle();
        rd_chk("R7 pre-set", 8'h34, 32'h0000_0020);
        @(negedge clk); pin_in[5] = 0;
        @(negedge clk);
        @(negedge clk); bus_wr = 1; bus_addr = 8'h34; bus_wdata = 32'h20;
        @(negedge clk); bus_wr = 0; bus_wdata = '0;
        rd_chk("R7 edge beats clear", 8'h34, 32'h0000_0020);
        wr(8'h34, 32'h0000_0020);
        rd_chk("R7 later clear", 8'h34, 32'd0);
        wr(8'h28, 32'h20);
        wr(8'h30, 32'h20);
    endtask

    task automatic t_banks();
        wr(8'h24, 32'h0000_0008);
        wr(8'h4C, 32'h1000_0100);
        @(negedge clk); pin_in[3] = 1; pin_in[40] = 1; pin_in[60] = 1; settle();
        chk("R8 gated off", 64'(bank_irq), 64'd0);
        wr(8'h08, 32'h0000_000F);
        @(negedge clk);
        chk("R8 routing", 64'(bank_irq), 64'b1101);
        wr(8'h08, 32'h0000_0007);
        @(negedge clk);
        chk("R8 per-bank gate", 64'(bank_irq), 64'b0101);
        wr(8'h34, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R8 status cleared", 64'(bank_irq), 64'b0100);
    endtask

    task automatic t_unmapped();
        rd_chk("R9 addr 0x00", 8'h00, 32'd0);
        rd_chk("R9 addr 0x60", 8'h60, 32'd0);
        rd_chk("R9 unaligned", 8'h11, 32'd0);
        @(negedge clk); bus_addr = 8'h10; #1;
        chk("R10 no strobe", 64'(bus_rdata), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_set_clear();
        t_input_sync();
        t_rising();
        t_falling_both();
        t_collision();
        t_banks();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule